// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides where a small processor core goes when it takes a synchronous exception or a debug exception. It also records the state the handler needs. A raise strobe brings in the faulting PC, a cause code and, optionally, a faulting virtual address. A debug strobe uses the same PC input and brings its own debug cause. In the cycle the request is accepted, the block updates the processor status word and the saved-state registers together. One cycle later it emits a single-cycle redirect pulse with the handler address.

The target vector is selected from the status flags. An exception raised while already in exception mode goes to the double-exception vector. Otherwise it goes to the user vector or the kernel vector, depending on the user-mode flag. A debug request is honoured only when the current interrupt level is below the configured debug level. The double-exception PC register and vector relocation are each enabled by a parameter. Plain write ports let the surrounding core load the status word and the vector base. A level-indexed read port returns the saved PC and the saved status word for any level.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `redirect` is 0, the status word is 0 and the cause and address registers are 0. The vector base register holds `RESET_VB`.
- R2: Status word fields are interrupt level in bits [3:0], exception mode (EXCM) in bit 4 and user mode (UM) in bit 5. An exception raised with EXCM clear and UM set saves the PC in the level-1 saved PC slot and targets the user vector.
- R3: An exception raised with EXCM clear and UM clear saves the PC in the level-1 slot and targets the kernel vector.
- R4: An exception raised with EXCM set targets the double-exception vector. With `HAS_DEPC`=1 the PC goes to the double-exception PC register and the level-1 slot is unchanged. With `HAS_DEPC`=0 the PC goes to the level-1 slot.
- R5: Every accepted exception loads the cause register and sets EXCM. The interrupt level and UM are left unchanged.
- R6: An accepted exception with `exc_addr_vld` high loads `exc_addr` into the address register. Without `exc_addr_vld`, the address register keeps its value.
- R7: The current level is the interrupt level field. While EXCM is set, the current level is raised to at least `EXCM_LEVEL`. A debug request is taken only if the current level is below `DBG_LEVEL`. Otherwise the request produces no redirect and no state change.
- R8: A taken debug request loads the debug cause and saves the PC and the old status word in the slots for `DBG_LEVEL`. It sets the interrupt level to `DBG_LEVEL`, sets EXCM, keeps UM and targets the debug vector.
- R9: With `RELOC`=1, the target is the fixed vector minus `RESET_VB` plus the vector base register. With `RELOC`=0, the fixed vector is used unchanged.
- R10: `redirect` is high for exactly the one cycle after an accepted request. When both requests arrive together, a takeable debug request wins and the exception is discarded, leaving its cause unrecorded. If the debug request is not takeable, the exception is accepted.
- R11: A status write in the same cycle as an accepted request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception raise strobe |
| req_pc | input | XLEN | Faulting PC for either request |
| exc_cause | input | CW | Exception cause code |
| exc_addr_vld | input | 1 | Faulting address present |
| exc_addr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug raise strobe |
| dbg_cause | input | CW | Debug cause code |
| ps_wr | input | 1 | Status word write strobe |
| ps_wdata | input | 6 | Status word write data |
| vb_wr | input | 1 | Vector base write strobe |
| vb_wdata | input | XLEN | Vector base write data |
| rd_lvl | input | LW | Level selected on the read port |
| redirect | output | 1 | One-cycle redirect pulse |
| redirect_vec | output | XLEN | Handler address |
| ps_o | output | 6 | Status word |
| exccause_o | output | CW | Exception cause register |
| excvaddr_o | output | XLEN | Exception virtual address register |
| dbgcause_o | output | CW | Debug cause register |
| depc_o | output | XLEN | Double-exception PC (0 when absent) |
| rd_epc | output | XLEN | Saved PC for `rd_lvl` |
| rd_eps | output | 6 | Saved status word for `rd_lvl` |

## Verification
The hardest situations to reach are those where EXCM alone decides the outcome. One is a debug request at interrupt level 0 that must still be dropped because EXCM raises the current level to the debug level. Another is a simultaneous raise in which the debug side loses and the exception must then be taken. The bench reaches both by loading the status word through its write port just before the strobe. It also chains two exceptions, so the second one arrives with EXCM set by the first. The bench then reads both saved-PC locations to confirm which one the second exception updated.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN       = 32,
  parameter int CW         = 6,
  parameter int NLEVEL     = 6,
  parameter int DBG_LEVEL  = 3,
  parameter int EXCM_LEVEL = 3,
  parameter bit HAS_DEPC   = 1'b1,
  parameter bit RELOC      = 1'b1,
  parameter logic [XLEN-1:0] RESET_VB   = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_KERNEL = 32'h4000_0300,
  parameter logic [XLEN-1:0] VEC_USER   = 32'h4000_0340,
  parameter logic [XLEN-1:0] VEC_DOUBLE = 32'h4000_03C0,
  parameter logic [XLEN-1:0] VEC_DEBUG  = 32'h4000_0280,
  localparam int LW = $clog2(NLEVEL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [XLEN-1:0] req_pc,
  input  logic [CW-1:0]   exc_cause,
  input  logic            exc_addr_vld,
  input  logic [XLEN-1:0] exc_addr,
  input  logic            dbg_req,
  input  logic [CW-1:0]   dbg_cause,
  input  logic            ps_wr,
  input  logic [5:0]      ps_wdata,
  input  logic            vb_wr,
  input  logic [XLEN-1:0] vb_wdata,
  input  logic [LW-1:0]   rd_lvl,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_vec,
  output logic [5:0]      ps_o,
  output logic [CW-1:0]   exccause_o,
  output logic [XLEN-1:0] excvaddr_o,
  output logic [CW-1:0]   dbgcause_o,
  output logic [XLEN-1:0] depc_o,
  output logic [XLEN-1:0] rd_epc,
  output logic [5:0]      rd_eps
);
  localparam int EXCM = 4;
  localparam int UM   = 5;

  logic [5:0]      ps;
  logic [XLEN-1:0] vecbase;
  logic [XLEN-1:0] epc [NLEVEL+1];
  logic [5:0]      eps [NLEVEL+1];
  logic [3:0]      cur_lvl;
  logic            dbg_take, exc_take, dbl;
  logic [XLEN-1:0] fixed_vec, tgt_vec;

  assign cur_lvl  = (ps[EXCM] && ps[3:0] < 4'(EXCM_LEVEL)) ? 4'(EXCM_LEVEL) : ps[3:0];
  assign dbg_take = dbg_req && (cur_lvl < 4'(DBG_LEVEL));
  assign exc_take = exc_req && !dbg_take;
  assign dbl      = ps[EXCM];

  always_comb begin
    if (dbg_take)     fixed_vec = VEC_DEBUG;
    else if (dbl)     fixed_vec = VEC_DOUBLE;
    else if (ps[UM])  fixed_vec = VEC_USER;
    else              fixed_vec = VEC_KERNEL;
  end

  generate
    if (RELOC) begin : g_reloc
      assign tgt_vec = fixed_vec - RESET_VB + vecbase;
    end else begin : g_fixed
      assign tgt_vec = fixed_vec;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps           <= '0;
      vecbase      <= RESET_VB;
      redirect     <= 1'b0;
      redirect_vec <= '0;
      exccause_o   <= '0;
      excvaddr_o   <= '0;
      dbgcause_o   <= '0;
      for (int i = 0; i <= NLEVEL; i++) begin
        epc[i] <= '0;
        eps[i] <= '0;
      end
    end else begin
      redirect <= dbg_take || exc_take;
      if (dbg_take || exc_take) redirect_vec <= tgt_vec;
      if (vb_wr) vecbase <= vb_wdata;
      if (dbg_take) begin
        dbgcause_o     <= dbg_cause;
        epc[DBG_LEVEL] <= req_pc;
        eps[DBG_LEVEL] <= ps;
        ps             <= {ps[UM], 1'b1, 4'(DBG_LEVEL)};
      end else if (exc_take) begin
        exccause_o <= exc_cause;
        if (exc_addr_vld) excvaddr_o <= exc_addr;
        if (!(dbl && HAS_DEPC)) epc[1] <= req_pc;
        ps[EXCM] <= 1'b1;
      end else if (ps_wr) begin
        ps <= ps_wdata;
      end
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk) begin
        if (!rst_n) depc_q <= '0;
        else if (exc_take && dbl) depc_q <= req_pc;
      end
      assign depc_o = depc_q;
    end else begin : g_nodepc
      assign depc_o = '0;
    end
  endgenerate

  assign ps_o   = ps;
  assign rd_epc = (int'(rd_lvl) <= NLEVEL) ? epc[rd_lvl] : '0;
  assign rd_eps = (int'(rd_lvl) <= NLEVEL) ? eps[rd_lvl] : '0;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN       = 32,
  parameter int DBG_LEVEL  = 3,
  parameter int EXCM_LEVEL = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            exc_addr_vld,
  input logic            dbg_req,
  input logic            ps_wr,
  input logic            redirect,
  input logic [5:0]      ps_o,
  input logic [XLEN-1:0] excvaddr_o
);
  logic [3:0] lvl_now;
  assign lvl_now = (ps_o[4] && ps_o[3:0] < 4'(EXCM_LEVEL)) ? 4'(EXCM_LEVEL) : ps_o[3:0];

  a_r5_excm_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ps_o[4]);

  a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(exc_req || dbg_req));

  a_r7_debug_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !exc_req && lvl_now >= 4'(DBG_LEVEL)) |=> !redirect);

  a_r8_debug_level: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && lvl_now < 4'(DBG_LEVEL)) |=> (redirect && ps_o[4] && ps_o[3:0] == 4'(DBG_LEVEL)));

  a_r4_double_keeps_ps: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !dbg_req && ps_o[4] && !ps_wr) |=> (redirect && ps_o == $past(ps_o)));

  a_r6_vaddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req && exc_addr_vld) |=> $stable(excvaddr_o));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .XLEN(XLEN), .DBG_LEVEL(DBG_LEVEL), .EXCM_LEVEL(EXCM_LEVEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_addr_vld(exc_addr_vld),
  .dbg_req(dbg_req), .ps_wr(ps_wr), .redirect(redirect), .ps_o(ps_o),
  .excvaddr_o(excvaddr_o)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam logic [31:0] VK = 32'h4000_0300;
  localparam logic [31:0] VU = 32'h4000_0340;
  localparam logic [31:0] VD = 32'h4000_03C0;
  localparam logic [31:0] VG = 32'h4000_0280;

  typedef struct packed {
    logic [5:0]  ps;
    logic        ex;
    logic        dg;
    logic        exp_r;
    logic [31:0] exp_vec;
    logic [5:0]  exp_ps;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{6'h20, 1'b1, 1'b0, 1'b1, VU, 6'h30},
    '{6'h00, 1'b1, 1'b0, 1'b1, VK, 6'h10},
    '{6'h10, 1'b1, 1'b0, 1'b1, VD, 6'h10},
    '{6'h32, 1'b1, 1'b0, 1'b1, VD, 6'h32},
    '{6'h02, 1'b0, 1'b1, 1'b1, VG, 6'h13},
    '{6'h21, 1'b0, 1'b1, 1'b1, VG, 6'h33},
    '{6'h03, 1'b0, 1'b1, 1'b0, 32'h0, 6'h03},
    '{6'h10, 1'b0, 1'b1, 1'b0, 32'h0, 6'h10},
    '{6'h0F, 1'b0, 1'b1, 1'b0, 32'h0, 6'h0F},
    '{6'h00, 1'b1, 1'b1, 1'b1, VG, 6'h13},
    '{6'h04, 1'b1, 1'b1, 1'b1, VK, 6'h14},
    '{6'h20, 1'b0, 1'b0, 1'b0, 32'h0, 6'h20}
  };

  logic clk = 0, rst_n = 0;
  logic exc_req = 0, exc_addr_vld = 0, dbg_req = 0, ps_wr = 0, vb_wr = 0;
  logic [31:0] req_pc = 0, exc_addr = 0, vb_wdata = 0;
  logic [5:0]  exc_cause = 0, dbg_cause = 0, ps_wdata = 0;
  logic [2:0]  rd_lvl = 0;
  logic        redirect;
  logic [31:0] redirect_vec, excvaddr_o, depc_o, rd_epc;
  logic [5:0]  ps_o, exccause_o, dbgcause_o, rd_eps;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .req_pc(req_pc),
    .exc_cause(exc_cause), .exc_addr_vld(exc_addr_vld), .exc_addr(exc_addr),
    .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .vb_wr(vb_wr), .vb_wdata(vb_wdata), .rd_lvl(rd_lvl), .redirect(redirect),
    .redirect_vec(redirect_vec), .ps_o(ps_o), .exccause_o(exccause_o),
    .excvaddr_o(excvaddr_o), .dbgcause_o(dbgcause_o), .depc_o(depc_o),
    .rd_epc(rd_epc), .rd_eps(rd_eps)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ps(input logic [5:0] v);
    @(negedge clk); ps_wr = 1; ps_wdata = v;
    @(negedge clk); ps_wr = 0;
  endtask

  task automatic fire(input logic ex, input logic dg, input logic [31:0] pc,
                      input logic [5:0] cause, input logic av, input logic [31:0] ad);
    exc_req = ex; dbg_req = dg; req_pc = pc; exc_cause = cause;
    dbg_cause = cause; exc_addr_vld = av; exc_addr = ad;
    @(negedge clk);
    exc_req = 0; dbg_req = 0; exc_addr_vld = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 redirect", 32'(redirect), 32'h0);
    chk("R1 ps", 32'(ps_o), 32'h0);
    chk("R1 exccause", 32'(exccause_o), 32'h0);
    chk("R1 excvaddr", excvaddr_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      set_ps(TBL[i].ps);
      fire(TBL[i].ex, TBL[i].dg, 32'h1000 + 32'(i), 6'(i + 1), 1'b0, 32'h0);
      chk($sformatf("R2/R3/R4/R5/R7/R8/R10 vec%0d redirect", i), 32'(redirect), 32'(TBL[i].exp_r));
      if (TBL[i].exp_r)
        chk($sformatf("R2/R3/R4/R8 vec%0d target", i), redirect_vec, TBL[i].exp_vec);
      chk($sformatf("R5/R7/R8 vec%0d ps", i), 32'(ps_o), 32'(TBL[i].exp_ps));
    end

    // R10: pulse lasts one cycle
    set_ps(6'h00);
    fire(1, 0, 32'h2000, 6'd7, 0, 0);
    chk("R10 pulse high", 32'(redirect), 32'h1);
    @(negedge clk);
    chk("R10 pulse low", 32'(redirect), 32'h0);

    // R4: chained exception goes to double PC, level-1 slot kept
    set_ps(6'h00);
    fire(1, 0, 32'hAAAA_0000, 6'd9, 0, 0);
    fire(1, 0, 32'hBBBB_0000, 6'd11, 0, 0);
    rd_lvl = 3'd1;
    #1;
    chk("R4 depc", depc_o, 32'hBBBB_0000);
    chk("R4 epc1 kept", rd_epc, 32'hAAAA_0000);
    chk("R5 cause", 32'(exccause_o), 32'd11);

    // R6: address loaded only with valid
    set_ps(6'h00);
    fire(1, 0, 32'h3000, 6'd2, 1, 32'hDEAD_BEE0);
    chk("R6 vaddr load", excvaddr_o, 32'hDEAD_BEE0);
    set_ps(6'h00);
    fire(1, 0, 32'h3004, 6'd3, 0, 32'h1111_1111);
    chk("R6 vaddr hold", excvaddr_o, 32'hDEAD_BEE0);

    // R8: debug saved state
    set_ps(6'h21);
    fire(0, 1, 32'h5550, 6'd5, 0, 0);
    rd_lvl = 3'd3;
    #1;
    chk("R8 dbg epc", rd_epc, 32'h5550);
    chk("R8 dbg eps", 32'(rd_eps), 32'h21);
    chk("R8 dbgcause", 32'(dbgcause_o), 32'd5);

    // R10: debug wins, exception cause not recorded
    set_ps(6'h00);
    fire(1, 0, 32'h6000, 6'd20, 0, 0);
    set_ps(6'h00);
    fire(1, 1, 32'h6004, 6'd33, 0, 0);
    chk("R10 exccause untouched", 32'(exccause_o), 32'd20);
    chk("R10 dbgcause", 32'(dbgcause_o), 32'd33);

    // R7: dropped debug changes nothing
    set_ps(6'h10);
    fire(0, 1, 32'h6100, 6'd44, 0, 0);
    chk("R7 dropped dbgcause", 32'(dbgcause_o), 32'd33);

    // R11: status write lost when request accepted
    set_ps(6'h20);
    @(negedge clk);
    ps_wr = 1; ps_wdata = 6'h07;
    fire(1, 0, 32'h7000, 6'd1, 0, 0);
    ps_wr = 0;
    chk("R11 ps write dropped", 32'(ps_o), 32'h30);

    // R9: relocation
    @(negedge clk); vb_wr = 1; vb_wdata = 32'h8000_1000;
    @(negedge clk); vb_wr = 0;
    set_ps(6'h20);
    fire(1, 0, 32'h7100, 6'd1, 0, 0);
    chk("R9 relocated user", redirect_vec, 32'h8000_1340);
    fire(1, 0, 32'h7104, 6'd1, 0, 0);
    chk("R9 relocated double", redirect_vec, 32'h8000_13C0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule